// File: doc/BRIEF.md
# Command Buffer Control Sequencer

This block is the control area of a buffer-based command/response interface to a security coprocessor. Host software writes a small set of 32-bit registers to walk the device through four states: Idle, Ready, Command Execution and Command Completion. Requests to enter Idle or Ready are single-bit handshakes. Software sets the bit, and the device clears it once the requested state has been reached. Each of these transitions is carried out by an external execution stub through a request/acknowledge pair.

A start register launches the command held in the buffer. A cancel register asks the stub to abandon a command that is running. A cycle counter watches every Idle/Ready transition. If the stub does not acknowledge within the configured bound, the block raises a sticky fatal-error status and refuses further work until reset.

A locality register pair tracks which of five requesters (0 to 4) owns the interface. It supports request, relinquish, higher-priority seize, and a reset-establishment action that only the two highest localities may perform. All registers share one word-addressed write/read port, and read data is registered.

Top module: `cmdbuf_ctrl_top`

## Requirements
- R1: After reset the status word reads 0x2 (Idle bit 1 set, fatal bit 0 clear). The request, start and cancel words read 0. The locality state reads 0x80. `xfer_req` is low.
- R2: Writing the request word (index 2) with bit 0 set starts a transition handshake with `xfer_to_idle` low. On `xfer_ack` the device enters Ready, status bit 1 reads 0, and request bit 0 reads 0.
- R3: Writing request bit 1 starts a handshake with `xfer_to_idle` high. On `xfer_ack` the device enters Idle, status bit 1 reads 1, and request bit 1 reads 0. When both bits are pending, the Idle transition is performed first.
- R4: Writing exactly 0x00000001 to the start word (index 5) in Ready, with no request pending and no handshake open, enters Command Execution. `exec_go` then pulses for one cycle and the start word reads 1.
- R5: While executing, an `exec_done` pulse enters Command Completion, and the start word reads back 0.
- R6: A start write is ignored when the device is in Idle or Completion, when a go-idle request is pending, or when the written value is not 0x00000001. In each case there is no `exec_go` pulse and the start word stays 0.
- R7: Writing 0x00000001 to the cancel word (index 4) sets it, writing 0 clears it, and any other value leaves it unchanged. `exec_cancel` is high from the cycle after the cancel word is 1 during execution, and drops the cycle after execution ends.
- R8: If a handshake stays unacknowledged for TMO_CYCLES cycles, status bit 0 (fatal) becomes 1 and the pending request bits are cleared. Until reset, request writes open no handshake and start writes are ignored.
- R9: A locality control write (index 1, bit 0 = request) from locality 0 to 4 while none is assigned grants that locality. The state word (index 0) then reads bit 7 = 1, bits 4:2 = the owner, and bit 1 = 1. A request from locality 5 or above, or while another locality is assigned, is ignored. Bit 1 (relinquish) from the owner unassigns it.
- R10: A seize (control bit 2) from a locality above the owner transfers ownership. A seize from the owner or a lower locality is ignored.
- R11: A reset-establishment write (control bit 3) from locality 3 or 4 sets state bit 0. The same write from localities 0 to 2 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write word index |
| wr_data | input | 32 | Write data |
| wr_loc | input | LOC_W | Locality issuing the access |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Read word index |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| xfer_req | output | 1 | Transition handshake open |
| xfer_to_idle | output | 1 | Target of the open handshake: 1 = Idle, 0 = Ready |
| xfer_ack | input | 1 | Stub acknowledges the transition |
| exec_go | output | 1 | One-cycle pulse launching the command |
| exec_done | input | 1 | Stub reports the command finished |
| exec_cancel | output | 1 | Cancellation requested for the running command |

## Verification
The assertions assume that the stub raises `xfer_ack` only while `xfer_req` is high, and `exec_done` only while a command runs. They also assume that at most one register write arrives per cycle. The directed bench keeps to this. Its stub task waits until it sees `xfer_req` before pulsing the acknowledge, and it pulses `exec_done` only after a start has been accepted. Every write and read is driven on the falling edge, one access per task.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;
  parameter int LOC_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READY = 2'd1,
    ST_EXEC  = 2'd2,
    ST_DONE  = 2'd3
  } cb_state_e;

  localparam int RIDX_LOC_STATE = 0;
  localparam int RIDX_LOC_CTRL  = 1;
  localparam int RIDX_REQ       = 2;
  localparam int RIDX_CANCEL    = 4;
  localparam int RIDX_STS       = 3;
  localparam int RIDX_START     = 5;
endpackage

// File: rtl/cmdbuf_tmo.sv
module cmdbuf_tmo #(
  parameter int TMO_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int TW = $clog2(TMO_CYCLES + 1);
  localparam logic [TW-1:0] LIMIT = TW'(TMO_CYCLES);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = run && (cnt_q == LIMIT);

  // R8: the window restarts whenever no handshake is open
  p_window_clear_r8: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/cmdbuf_locality.sv
module cmdbuf_locality
  import cmdbuf_pkg::*;
#(
  parameter int NUM_LOC     = 5,
  parameter int EST_MIN_LOC = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_stb,
  input  logic [3:0]       ctl_data,
  input  logic [LOC_W-1:0] src_loc,
  output logic [LOC_W-1:0] active_q,
  output logic             assigned_q,
  output logic             estab_q
);
  localparam logic [LOC_W-1:0] LOC_LIMIT = LOC_W'(NUM_LOC);
  localparam logic [LOC_W-1:0] EST_MIN   = LOC_W'(EST_MIN_LOC);

  logic src_ok;
  assign src_ok = (src_loc < LOC_LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q   <= '0;
      assigned_q <= 1'b0;
      estab_q    <= 1'b0;
    end else if (ctl_stb && src_ok) begin
      if (ctl_data[3] && (src_loc >= EST_MIN)) estab_q <= 1'b1;
      if (ctl_data[1] && assigned_q && (src_loc == active_q)) begin
        assigned_q <= 1'b0;
      end else if (ctl_data[2] && assigned_q && (src_loc > active_q)) begin
        active_q <= src_loc;
      end else if (ctl_data[0] && !assigned_q) begin
        assigned_q <= 1'b1;
        active_q   <= src_loc;
      end
    end
  end

  p_owner_in_range_r9: assert property (@(posedge clk) disable iff (rst)
    assigned_q |-> (active_q < LOC_LIMIT));
  p_estab_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    estab_q |=> estab_q);
  p_seize_up_only_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(assigned_q) && assigned_q && (active_q != $past(active_q)))
      |-> (active_q > $past(active_q)));
endmodule

// File: rtl/cmdbuf_seq.sv
module cmdbuf_seq
  import cmdbuf_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req_stb,
  input  logic [1:0]  req_bits,
  input  logic        start_stb,
  input  logic        cancel_stb,
  input  logic [31:0] wdata,
  input  logic        xfer_ack,
  input  logic        exec_done,
  input  logic        tmo_expired,
  output cb_state_e   st_q,
  output logic        req_rdy_q,
  output logic        req_idle_q,
  output logic        start_q,
  output logic        cancel_q,
  output logic        fatal_q,
  output logic        xfer_req_q,
  output logic        xfer_to_idle_q,
  output logic        exec_go_q,
  output logic        exec_cancel_q
);
  logic word_one, word_zero;
  assign word_one  = (wdata == 32'd1);
  assign word_zero = (wdata == 32'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q           <= ST_IDLE;
      req_rdy_q      <= 1'b0;
      req_idle_q     <= 1'b0;
      start_q        <= 1'b0;
      cancel_q       <= 1'b0;
      fatal_q        <= 1'b0;
      xfer_req_q     <= 1'b0;
      xfer_to_idle_q <= 1'b0;
      exec_go_q      <= 1'b0;
      exec_cancel_q  <= 1'b0;
    end else begin
      exec_go_q     <= 1'b0;
      exec_cancel_q <= cancel_q && (st_q == ST_EXEC);

      if (cancel_stb) begin
        if (word_one)       cancel_q <= 1'b1;
        else if (word_zero) cancel_q <= 1'b0;
      end

      if (!fatal_q) begin
        if (req_stb) begin
          if (req_bits[0]) req_rdy_q  <= 1'b1;
          if (req_bits[1]) req_idle_q <= 1'b1;
        end

        if (xfer_req_q) begin
          if (xfer_ack) begin
            xfer_req_q <= 1'b0;
            if (xfer_to_idle_q) begin
              st_q       <= ST_IDLE;
              req_idle_q <= 1'b0;
            end else begin
              st_q      <= ST_READY;
              req_rdy_q <= 1'b0;
            end
          end else if (tmo_expired) begin
            fatal_q    <= 1'b1;
            xfer_req_q <= 1'b0;
            req_rdy_q  <= 1'b0;
            req_idle_q <= 1'b0;
          end
        end else if ((st_q != ST_EXEC) && (req_idle_q || req_rdy_q)) begin
          xfer_req_q     <= 1'b1;
          xfer_to_idle_q <= req_idle_q;
        end else if (start_stb && word_one && (st_q == ST_READY) && !req_idle_q) begin
          st_q      <= ST_EXEC;
          start_q   <= 1'b1;
          exec_go_q <= 1'b1;
        end

        if ((st_q == ST_EXEC) && exec_done) begin
          st_q    <= ST_DONE;
          start_q <= 1'b0;
        end
      end
    end
  end

  p_go_enters_exec_r4: assert property (@(posedge clk) disable iff (rst)
    exec_go_q |-> (st_q == ST_EXEC) && start_q);
  p_done_clears_start_r5: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_EXEC) && exec_done && !fatal_q) |=> !start_q);
  p_idle_ack_r3: assert property (@(posedge clk) disable iff (rst)
    (xfer_req_q && xfer_ack && xfer_to_idle_q && !fatal_q)
      |=> (st_q == ST_IDLE) && !req_idle_q);
  p_fatal_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    fatal_q |=> fatal_q && !exec_go_q && !xfer_req_q);
  p_no_xfer_in_exec_r2: assert property (@(posedge clk) disable iff (rst)
    xfer_req_q |-> (st_q != ST_EXEC));
endmodule

// File: rtl/cmdbuf_ctrl_top.sv
module cmdbuf_ctrl_top
  import cmdbuf_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int TMO_CYCLES = 1000,
  parameter int NUM_LOC    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [LOC_W-1:0]  wr_loc,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              xfer_req,
  output logic              xfer_to_idle,
  input  logic              xfer_ack,
  output logic              exec_go,
  input  logic              exec_done,
  output logic              exec_cancel
);
  logic loc_stb, req_stb, start_stb, cancel_stb;
  assign loc_stb    = wr_en && (wr_addr == ADDR_W'(RIDX_LOC_CTRL));
  assign req_stb    = wr_en && (wr_addr == ADDR_W'(RIDX_REQ));
  assign start_stb  = wr_en && (wr_addr == ADDR_W'(RIDX_START));
  assign cancel_stb = wr_en && (wr_addr == ADDR_W'(RIDX_CANCEL));

  cb_state_e        st_q;
  logic             req_rdy_q, req_idle_q, start_q, cancel_q, fatal_q;
  logic             tmo_expired;
  logic [LOC_W-1:0] active_q;
  logic             assigned_q, estab_q;

  cmdbuf_seq u_seq (
    .clk            (clk),
    .rst            (rst),
    .req_stb        (req_stb),
    .req_bits       (wr_data[1:0]),
    .start_stb      (start_stb),
    .cancel_stb     (cancel_stb),
    .wdata          (wr_data),
    .xfer_ack       (xfer_ack),
    .exec_done      (exec_done),
    .tmo_expired    (tmo_expired),
    .st_q           (st_q),
    .req_rdy_q      (req_rdy_q),
    .req_idle_q     (req_idle_q),
    .start_q        (start_q),
    .cancel_q       (cancel_q),
    .fatal_q        (fatal_q),
    .xfer_req_q     (xfer_req),
    .xfer_to_idle_q (xfer_to_idle),
    .exec_go_q      (exec_go),
    .exec_cancel_q  (exec_cancel)
  );

  cmdbuf_tmo #(.TMO_CYCLES(TMO_CYCLES)) u_tmo (
    .clk     (clk),
    .rst     (rst),
    .run     (xfer_req),
    .expired (tmo_expired)
  );

  cmdbuf_locality #(.NUM_LOC(NUM_LOC), .EST_MIN_LOC(3)) u_loc (
    .clk        (clk),
    .rst        (rst),
    .ctl_stb    (loc_stb),
    .ctl_data   (wr_data[3:0]),
    .src_loc    (wr_loc),
    .active_q   (active_q),
    .assigned_q (assigned_q),
    .estab_q    (estab_q)
  );

  logic [31:0]      rd_mux;
  logic [LOC_W-1:0] shown_loc;
  assign shown_loc = assigned_q ? active_q : '0;

  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      ADDR_W'(RIDX_LOC_STATE): rd_mux = {24'd0, 1'b1, 2'b00, shown_loc, assigned_q, estab_q};
      ADDR_W'(RIDX_REQ):       rd_mux = {30'd0, req_idle_q, req_rdy_q};
      ADDR_W'(RIDX_STS):       rd_mux = {30'd0, (st_q == ST_IDLE), fatal_q};
      ADDR_W'(RIDX_CANCEL):    rd_mux = {31'd0, cancel_q};
      ADDR_W'(RIDX_START):     rd_mux = {31'd0, start_q};
      default:                 rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  p_cancel_only_exec_r7: assert property (@(posedge clk) disable iff (rst)
    exec_cancel |-> $past(cancel_q) && ($past(st_q) == ST_EXEC));
endmodule

// File: tb/cmdbuf_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module cmdbuf_ctrl_top_tb_top;
  localparam int TMO = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  wr_loc = '0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        xfer_req, xfer_to_idle, exec_go, exec_cancel;
  logic        xfer_ack = 1'b0;
  logic        exec_done = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cmdbuf_ctrl_top #(.ADDR_W(4), .TMO_CYCLES(TMO), .NUM_LOC(5)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_loc(wr_loc), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .xfer_req(xfer_req), .xfer_to_idle(xfer_to_idle), .xfer_ack(xfer_ack),
    .exec_go(exec_go), .exec_done(exec_done), .exec_cancel(exec_cancel)
  );

  localparam logic [3:0] A_LST = 4'd0, A_LCT = 4'd1, A_REQ = 4'd2,
                         A_STS = 4'd3, A_CAN = 4'd4, A_STA = 4'd5;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [2:0] loc);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_loc = loc;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    idle_cycles(3);
    rst = 1'b0;
  endtask

  task automatic wait_xfer(input string req, input logic exp_idle);
    bit seen = 1'b0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (xfer_req) seen = 1'b1;
    end
    chk({req, " handshake opened"}, 32'(seen), 32'd1);
    chk({req, " handshake target"}, 32'(xfer_to_idle), 32'(exp_idle));
  endtask

  task automatic ack();
    xfer_ack = 1'b1;
    @(negedge clk);
    xfer_ack = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk); exec_done = 1'b1;
    @(negedge clk); exec_done = 1'b0;
  endtask

  task automatic go_ready();
    wr(A_REQ, 32'd1, 3'd0);
    wait_xfer("R2", 1'b0);
    ack();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    rd(A_STS, v); chk("R1 status", v, 32'h2);
    rd(A_REQ, v); chk("R1 request", v, 32'h0);
    rd(A_STA, v); chk("R1 start", v, 32'h0);
    rd(A_CAN, v); chk("R1 cancel", v, 32'h0);
    rd(A_LST, v); chk("R1 locality state", v, 32'h80);
    chk("R1 xfer_req", 32'(xfer_req), 32'd0);
  endtask

  task automatic t_ready();
    logic [31:0] v;
    do_reset();
    go_ready();
    rd(A_REQ, v); chk("R2 request cleared", v, 32'h0);
    rd(A_STS, v); chk("R2 status ready", v, 32'h0);
  endtask

  task automatic t_goidle();
    logic [31:0] v;
    do_reset();
    go_ready();
    wr(A_REQ, 32'd3, 3'd0);
    wait_xfer("R3 idle first", 1'b1);
    ack();
    rd(A_REQ, v); chk("R3 idle bit cleared, ready pending", v, 32'h1);
    rd(A_STS, v); chk("R3 status idle", v, 32'h2);
    wait_xfer("R3 ready second", 1'b0);
    ack();
    rd(A_REQ, v); chk("R3 both cleared", v, 32'h0);
  endtask

  task automatic t_exec();
    logic [31:0] v;
    do_reset();
    go_ready();
    wr(A_STA, 32'd1, 3'd0);
    chk("R4 exec_go pulse", 32'(exec_go), 32'd1);
    @(negedge clk);
    chk("R4 exec_go single cycle", 32'(exec_go), 32'd0);
    rd(A_STA, v); chk("R4 start reads 1", v, 32'h1);
    done_pulse();
    rd(A_STA, v); chk("R5 start back to 0", v, 32'h0);
    rd(A_STS, v); chk("R5 status not idle", v, 32'h0);
  endtask

  task automatic t_start_ignored();
    logic [31:0] v;
    bit go_seen;
    do_reset();
    wr(A_STA, 32'd1, 3'd0);
    chk("R6 start in idle no go", 32'(exec_go), 32'd0);
    rd(A_STA, v); chk("R6 start in idle", v, 32'h0);
    go_ready();
    wr(A_STA, 32'd3, 3'd0);
    chk("R6 wrong value no go", 32'(exec_go), 32'd0);
    rd(A_STA, v); chk("R6 wrong value", v, 32'h0);
    wr(A_REQ, 32'd2, 3'd0);
    wr(A_STA, 32'd1, 3'd0);
    chk("R6 go-idle pending no go", 32'(exec_go), 32'd0);
    rd(A_STA, v); chk("R6 go-idle pending", v, 32'h0);
    wait_xfer("R6 idle", 1'b1);
    ack();
    go_ready();
    wr(A_STA, 32'd1, 3'd0);
    done_pulse();
    go_seen = 1'b0;
    wr(A_STA, 32'd1, 3'd0);
    if (exec_go) go_seen = 1'b1;
    chk("R6 start in completion no go", 32'(go_seen), 32'd0);
    rd(A_STA, v); chk("R6 start in completion", v, 32'h0);
  endtask

  task automatic t_cancel();
    logic [31:0] v;
    do_reset();
    go_ready();
    wr(A_STA, 32'd1, 3'd0);
    wr(A_CAN, 32'd1, 3'd0);
    @(negedge clk);
    chk("R7 exec_cancel raised", 32'(exec_cancel), 32'd1);
    rd(A_CAN, v); chk("R7 cancel reads 1", v, 32'h1);
    wr(A_CAN, 32'd5, 3'd0);
    rd(A_CAN, v); chk("R7 other value ignored", v, 32'h1);
    done_pulse();
    @(negedge clk);
    chk("R7 exec_cancel drops after exec", 32'(exec_cancel), 32'd0);
    wr(A_CAN, 32'd0, 3'd0);
    rd(A_CAN, v); chk("R7 cancel cleared", v, 32'h0);
  endtask

  task automatic t_timeout();
    logic [31:0] v;
    bit seen;
    do_reset();
    wr(A_REQ, 32'd1, 3'd0);
    wait_xfer("R8", 1'b0);
    idle_cycles(TMO - 10);
    rd(A_STS, v); chk("R8 no fatal before bound", v, 32'h2);
    idle_cycles(20);
    rd(A_STS, v); chk("R8 fatal set", v, 32'h3);
    rd(A_REQ, v); chk("R8 request cleared", v, 32'h0);
    chk("R8 handshake dropped", 32'(xfer_req), 32'd0);
    wr(A_REQ, 32'd1, 3'd0);
    seen = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (xfer_req) seen = 1'b1;
    end
    chk("R8 no handshake after fatal", 32'(seen), 32'd0);
    wr(A_STA, 32'd1, 3'd0);
    chk("R8 start ignored after fatal", 32'(exec_go), 32'd0);
    rd(A_STA, v); chk("R8 start word after fatal", v, 32'h0);
  endtask

  task automatic t_locality();
    logic [31:0] v;
    do_reset();
    wr(A_LCT, 32'h1, 3'd5); rd(A_LST, v); chk("R9 locality 5 ignored", v, 32'h80);
    wr(A_LCT, 32'h1, 3'd2); rd(A_LST, v); chk("R9 grant locality 2", v, 32'h8A);
    wr(A_LCT, 32'h1, 3'd1); rd(A_LST, v); chk("R9 request while owned", v, 32'h8A);
    wr(A_LCT, 32'h4, 3'd1); rd(A_LST, v); chk("R10 lower seize ignored", v, 32'h8A);
    wr(A_LCT, 32'h4, 3'd4); rd(A_LST, v); chk("R10 seize by 4", v, 32'h92);
    wr(A_LCT, 32'h8, 3'd2); rd(A_LST, v); chk("R11 establishment from 2 ignored", v, 32'h92);
    wr(A_LCT, 32'h2, 3'd2); rd(A_LST, v); chk("R9 relinquish by non-owner", v, 32'h92);
    wr(A_LCT, 32'h2, 3'd4); rd(A_LST, v); chk("R9 relinquish by owner", v, 32'h80);
    wr(A_LCT, 32'h8, 3'd3); rd(A_LST, v); chk("R11 establishment from 3", v, 32'h81);
  endtask

  initial begin
    t_reset();
    t_ready();
    t_goidle();
    t_exec();
    t_start_ignored();
    t_cancel();
    t_timeout();
    t_locality();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule